// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block is the trap-entry stage of a small 32-bit in-order processor that has branch delay slots. In each cycle it looks at four trap sources: an external interrupt, a break, a general hardware exception and an address-translation (MMU) fault. It picks at most one of them. It then works out everything the core must write to take that trap: the return address and the register it goes into, the new program counter, the new status word, the exception syndrome, the fault address and the saved branch target.

All results leave the block from registers. Each destination has its own write strobe, and each strobe is high for exactly one cycle: the cycle after the request was sampled. The core supplies its current PC, status word, instruction-state flags (delay slot, after an immediate prefix, branch used an immediate prefix), pending branch target and faulting address. It also supplies the details of the fault. A configuration input states whether hardware exceptions are implemented. The vector base is an input. A recursive MMU fault is reported on its own output.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is active, and in every cycle after a cycle with no trap taken, every write strobe (`linkWe`, `pcWe`, `statusWe`, `syndWe`, `faultAddrWe`, `btrWe`, `stateClr`) and `recursiveFault` are low.
- R2: A trap sampled on one clock edge drives `pcWe` high for the following cycle, with `pcNext` = `vecBase` + 0x10 for an interrupt, + 0x18 for a break, and + 0x20 for a hardware exception or an MMU fault.
- R3: When several requests are pending at once, at most one trap is taken. The MMU fault wins, then the hardware exception, then the break, then the interrupt.
- R4: An interrupt is taken only if status bit 1 (interrupt enable) is set, status bit 9 (exception in progress) and status bit 3 (break in progress) are both clear, and neither `inDelaySlot` nor `afterImm` is set.
- R5: Taking an interrupt writes `curPc` to link register 14 and clears status bit 1.
- R6: Taking a break writes `curPc` to link register 16 and sets status bit 3.
- R7: Taking a hardware exception sets status bit 9 and writes `curPc`+4 to link register 17. It writes the syndrome as `hweCause` (bits 4:0) with bit 12 equal to `inDelaySlot`. When `inDelaySlot` is set, `branchTarget` is written with `btrWe`; otherwise `btrWe` stays low.
- R8: Taking an MMU fault sets status bit 9 and writes link register 17. The value is `curPc`-8 when `inDelaySlot` and `branchUsedImm` are both set, and `curPc`-4 when only `inDelaySlot` is set. It is also `curPc`-4 when `afterImm` is set outside a delay slot. In every other case it is `curPc`. As with a hardware exception, `branchTarget` is written only from a delay slot.
- R9: The MMU fault syndrome code is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is set for a store that is not a fetch. Bit 12 equals `inDelaySlot`. All other bits are zero.
- R10: On every trap, the new status has bit 11 (user mode) moved into bit 12 and bit 13 (virtual mode) moved into bit 14. Bits 11 and 13 are cleared. All other bits follow the per-trap rules above.
- R11: Every trap taken raises `stateClr` for one cycle. The core uses it to clear its instruction-state flags and to drop its load reservation.
- R12: When `cfgExcEn` is low, a hardware exception request is ignored. Lower-priority requests are arbitrated as if it were absent.
- R13: If an MMU fault request is present in the cycle in which the strobes of a previous MMU fault are out, no trap is taken. `recursiveFault` is high for the following cycle.
- R14: `faultAddrWe` rises, with `faultAddrOut` = `faultAddrIn`, only for an MMU fault or for a hardware exception whose cause is 1 (unaligned access).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgExcEn | input | 1 | Hardware exceptions are implemented |
| vecBase | input | 32 | Trap vector base address |
| irqReq | input | 1 | External interrupt pending |
| brkReq | input | 1 | Break pending |
| hweReq | input | 1 | Hardware exception pending |
| hweCause | input | 5 | Hardware exception cause code |
| mmuReq | input | 1 | MMU fault pending |
| mmuIsFetch | input | 1 | Faulting access was an instruction fetch |
| mmuIsStore | input | 1 | Faulting access was a store |
| mmuIsProt | input | 1 | Fault was a protection fault (else a miss) |
| curPc | input | 32 | PC of the current instruction |
| curStatus | input | 32 | Current status word |
| inDelaySlot | input | 1 | Current instruction sits in a delay slot |
| afterImm | input | 1 | Current instruction follows an immediate prefix |
| branchUsedImm | input | 1 | Pending branch carried an immediate prefix |
| branchTarget | input | 32 | Pending branch target |
| faultAddrIn | input | 32 | Faulting data or fetch address |
| linkWe | output | 1 | Link register write strobe |
| linkSel | output | 5 | Link register index (14, 16 or 17) |
| linkData | output | 32 | Return address |
| pcWe | output | 1 | PC write strobe |
| pcNext | output | 32 | Trap vector |
| statusWe | output | 1 | Status write strobe |
| statusNext | output | 32 | New status word |
| syndWe | output | 1 | Syndrome write strobe |
| syndNext | output | 32 | New syndrome |
| faultAddrWe | output | 1 | Fault address write strobe |
| faultAddrOut | output | 32 | Fault address value |
| btrWe | output | 1 | Branch-target register write strobe |
| btrOut | output | 32 | Branch target value |
| stateClr | output | 1 | Clear instruction-state flags and reservation |
| recursiveFault | output | 1 | Recursive MMU fault detected |

## Verification
The bench sweeps every combination of the four requests together with the delay-slot, immediate-prefix, status-gating, configuration and fault-kind inputs. It compares every strobe and value with a model computed from the requirements. The MMU return-address selection gets special attention. A design that mixes up the delay-slot and immediate-prefix cases would resume one instruction off, or re-execute the wrong instruction. A swapped priority, or a missing interrupt gate, would show as the wrong link register or the wrong vector. A mode shift done in the wrong direction, or without first clearing the old saved copies, would leave stale user or virtual mode bits behind. A separate sequence holds an MMU fault for two cycles. A design that missed the recursion would take a second trap instead of flagging it.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_IRQ,
    TK_BRK,
    TK_HWE,
    TK_MMU
  } trapKind_e;

  // write strobes issued by the control half to the datapath half
  typedef struct packed {
    logic link;
    logic pc;
    logic status;
    logic synd;
    logic fault;
    logic btr;
    logic clr;
  } trapStb_t;

  // status word bit positions (the mode shift depends on these)
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = 12;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = 14;

  // syndrome bit positions
  localparam int SY_STORE = 10;
  localparam int SY_DS    = 12;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int CAUSE_W         = 5,
  parameter int UNALIGNED_CAUSE = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqReq,
  input  logic               brkReq,
  input  logic               hweReq,
  input  logic               mmuReq,
  input  logic               cfgExcEn,
  input  logic               statusIe,
  input  logic               statusEip,
  input  logic               statusBip,
  input  logic               inDelaySlot,
  input  logic               afterImm,
  input  logic [CAUSE_W-1:0] hweCause,
  output trapKind_e          kind,
  output trapStb_t           stb,
  output logic               recursiveHit
);

  logic mmuBusy;
  logic irqOk;
  logic hweOk;
  logic isExc;

  assign irqOk        = irqReq && statusIe && !statusEip && !statusBip && !inDelaySlot && !afterImm;
  assign hweOk        = hweReq && cfgExcEn;
  assign recursiveHit = mmuReq && mmuBusy;

  always_comb begin
    if (recursiveHit)  kind = TK_NONE;
    else if (mmuReq)   kind = TK_MMU;
    else if (hweOk)    kind = TK_HWE;
    else if (brkReq)   kind = TK_BRK;
    else if (irqOk)    kind = TK_IRQ;
    else               kind = TK_NONE;
  end

  assign isExc = (kind == TK_HWE) || (kind == TK_MMU);

  always_comb begin
    stb        = '0;
    stb.link   = (kind != TK_NONE);
    stb.pc     = (kind != TK_NONE);
    stb.status = (kind != TK_NONE);
    stb.clr    = (kind != TK_NONE);
    stb.synd   = isExc;
    stb.btr    = isExc && inDelaySlot;
    stb.fault  = (kind == TK_MMU) ||
                 ((kind == TK_HWE) && (hweCause == CAUSE_W'(UNALIGNED_CAUSE)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) mmuBusy <= 1'b0;
    else       mmuBusy <= (kind == TK_MMU);
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (kind == TK_IRQ) |-> (statusIe && !statusEip && !statusBip && !inDelaySlot && !afterImm)); // R4
  AST_MMU_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (mmuReq && !mmuBusy) |-> (kind == TK_MMU)); // R3
  AST_HWE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgExcEn |-> (kind != TK_HWE)); // R12
  AST_NO_MMU_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (kind == TK_MMU) |=> (kind != TK_MMU)); // R13

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 5,
  parameter int IDX_W     = 5,
  parameter int VEC_IRQ   = 'h10,
  parameter int VEC_BRK   = 'h18,
  parameter int VEC_EXC   = 'h20,
  parameter int LINK_IRQ  = 14,
  parameter int LINK_BRK  = 16,
  parameter int LINK_EXC  = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapKind_e          kind,
  input  trapStb_t           stb,
  input  logic               recursiveHit,
  input  logic [XLEN-1:0]    vecBase,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    curStatus,
  input  logic               inDelaySlot,
  input  logic               afterImm,
  input  logic               branchUsedImm,
  input  logic [XLEN-1:0]    branchTarget,
  input  logic [XLEN-1:0]    faultAddrIn,
  input  logic [CAUSE_W-1:0] hweCause,
  input  logic               mmuIsFetch,
  input  logic               mmuIsStore,
  input  logic               mmuIsProt,
  output logic               linkWe,
  output logic [IDX_W-1:0]   linkSel,
  output logic [XLEN-1:0]    linkData,
  output logic               pcWe,
  output logic [XLEN-1:0]    pcNext,
  output logic               statusWe,
  output logic [XLEN-1:0]    statusNext,
  output logic               syndWe,
  output logic [XLEN-1:0]    syndNext,
  output logic               faultAddrWe,
  output logic [XLEN-1:0]    faultAddrOut,
  output logic               btrWe,
  output logic [XLEN-1:0]    btrOut,
  output logic               stateClr,
  output logic               recursiveFault
);

  localparam logic [XLEN-1:0] MODE_LIVE   = (XLEN'(1) << ST_UM)  | (XLEN'(1) << ST_VM);
  localparam logic [XLEN-1:0] MODE_SAVED  = (XLEN'(1) << ST_UMS) | (XLEN'(1) << ST_VMS);

  logic [XLEN-1:0]  retAddr;
  logic [XLEN-1:0]  mmuRet;
  logic [XLEN-1:0]  vecOff;
  logic [IDX_W-1:0] selIdx;
  logic [XLEN-1:0]  stKind;
  logic [XLEN-1:0]  stFinal;
  logic [XLEN-1:0]  synd;
  logic [4:0]       mmuCode;

  // MMU fault return: re-execute the branch, the prefix, or the faulting insn
  always_comb begin
    if (inDelaySlot)   mmuRet = branchUsedImm ? (curPc - XLEN'(8)) : (curPc - XLEN'(4));
    else if (afterImm) mmuRet = curPc - XLEN'(4);
    else               mmuRet = curPc;
  end

  assign mmuCode = 5'd16 + {3'b000, !mmuIsProt, mmuIsFetch};

  always_comb begin
    retAddr = curPc;
    vecOff  = XLEN'(VEC_EXC);
    selIdx  = IDX_W'(LINK_EXC);
    stKind  = curStatus;
    synd    = '0;
    case (kind)
      TK_IRQ: begin
        vecOff         = XLEN'(VEC_IRQ);
        selIdx         = IDX_W'(LINK_IRQ);
        stKind[ST_IE]  = 1'b0;
      end
      TK_BRK: begin
        vecOff         = XLEN'(VEC_BRK);
        selIdx         = IDX_W'(LINK_BRK);
        stKind[ST_BIP] = 1'b1;
      end
      TK_HWE: begin
        retAddr        = curPc + XLEN'(4);
        stKind[ST_EIP] = 1'b1;
        synd           = XLEN'(hweCause);
        synd[SY_DS]    = inDelaySlot;
      end
      TK_MMU: begin
        retAddr        = mmuRet;
        stKind[ST_EIP] = 1'b1;
        synd           = XLEN'(mmuCode);
        synd[SY_STORE] = mmuIsStore && !mmuIsFetch;
        synd[SY_DS]    = inDelaySlot;
      end
      default: ;
    endcase
  end

  // push live mode bits one place up into their saved copies
  assign stFinal = (stKind & ~(MODE_LIVE | MODE_SAVED)) | ((stKind & MODE_LIVE) << 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkWe         <= 1'b0;
      pcWe           <= 1'b0;
      statusWe       <= 1'b0;
      syndWe         <= 1'b0;
      faultAddrWe    <= 1'b0;
      btrWe          <= 1'b0;
      stateClr       <= 1'b0;
      recursiveFault <= 1'b0;
      linkSel        <= '0;
      linkData       <= '0;
      pcNext         <= '0;
      statusNext     <= '0;
      syndNext       <= '0;
      faultAddrOut   <= '0;
      btrOut         <= '0;
    end else begin
      linkWe         <= stb.link;
      pcWe           <= stb.pc;
      statusWe       <= stb.status;
      syndWe         <= stb.synd;
      faultAddrWe    <= stb.fault;
      btrWe          <= stb.btr;
      stateClr       <= stb.clr;
      recursiveFault <= recursiveHit;
      linkSel        <= selIdx;
      linkData       <= retAddr;
      pcNext         <= vecBase + vecOff;
      statusNext     <= stFinal;
      syndNext       <= synd;
      faultAddrOut   <= faultAddrIn;
      btrOut         <= branchTarget;
    end
  end

  AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> (!statusNext[ST_UM] && !statusNext[ST_VM])); // R10
  AST_FAULT_WITH_SYND: assert property (@(posedge clk) disable iff (!rstN)
    faultAddrWe |-> syndWe); // R14
  AST_IRQ_IE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (linkWe && linkSel == IDX_W'(LINK_IRQ)) |-> !statusNext[ST_IE]); // R5
  AST_RECURSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    recursiveFault |-> (!pcWe && !stateClr)); // R13
  AST_CLR_WITH_PC: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> stateClr); // R11

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN            = 32,
  parameter int CAUSE_W         = 5,
  parameter int IDX_W           = 5,
  parameter int UNALIGNED_CAUSE = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgExcEn,
  input  logic [XLEN-1:0]    vecBase,
  input  logic               irqReq,
  input  logic               brkReq,
  input  logic               hweReq,
  input  logic [CAUSE_W-1:0] hweCause,
  input  logic               mmuReq,
  input  logic               mmuIsFetch,
  input  logic               mmuIsStore,
  input  logic               mmuIsProt,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    curStatus,
  input  logic               inDelaySlot,
  input  logic               afterImm,
  input  logic               branchUsedImm,
  input  logic [XLEN-1:0]    branchTarget,
  input  logic [XLEN-1:0]    faultAddrIn,
  output logic               linkWe,
  output logic [IDX_W-1:0]   linkSel,
  output logic [XLEN-1:0]    linkData,
  output logic               pcWe,
  output logic [XLEN-1:0]    pcNext,
  output logic               statusWe,
  output logic [XLEN-1:0]    statusNext,
  output logic               syndWe,
  output logic [XLEN-1:0]    syndNext,
  output logic               faultAddrWe,
  output logic [XLEN-1:0]    faultAddrOut,
  output logic               btrWe,
  output logic [XLEN-1:0]    btrOut,
  output logic               stateClr,
  output logic               recursiveFault
);

  trapKind_e kind;
  trapStb_t  stb;
  logic      recursiveHit;

  trap_ctrl #(
    .CAUSE_W        (CAUSE_W),
    .UNALIGNED_CAUSE(UNALIGNED_CAUSE)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .brkReq      (brkReq),
    .hweReq      (hweReq),
    .mmuReq      (mmuReq),
    .cfgExcEn    (cfgExcEn),
    .statusIe    (curStatus[ST_IE]),
    .statusEip   (curStatus[ST_EIP]),
    .statusBip   (curStatus[ST_BIP]),
    .inDelaySlot (inDelaySlot),
    .afterImm    (afterImm),
    .hweCause    (hweCause),
    .kind        (kind),
    .stb         (stb),
    .recursiveHit(recursiveHit)
  );

  trap_datapath #(
    .XLEN   (XLEN),
    .CAUSE_W(CAUSE_W),
    .IDX_W  (IDX_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .kind          (kind),
    .stb           (stb),
    .recursiveHit  (recursiveHit),
    .vecBase       (vecBase),
    .curPc         (curPc),
    .curStatus     (curStatus),
    .inDelaySlot   (inDelaySlot),
    .afterImm      (afterImm),
    .branchUsedImm (branchUsedImm),
    .branchTarget  (branchTarget),
    .faultAddrIn   (faultAddrIn),
    .hweCause      (hweCause),
    .mmuIsFetch    (mmuIsFetch),
    .mmuIsStore    (mmuIsStore),
    .mmuIsProt     (mmuIsProt),
    .linkWe        (linkWe),
    .linkSel       (linkSel),
    .linkData      (linkData),
    .pcWe          (pcWe),
    .pcNext        (pcNext),
    .statusWe      (statusWe),
    .statusNext    (statusNext),
    .syndWe        (syndWe),
    .syndNext      (syndNext),
    .faultAddrWe   (faultAddrWe),
    .faultAddrOut  (faultAddrOut),
    .btrWe         (btrWe),
    .btrOut        (btrOut),
    .stateClr      (stateClr),
    .recursiveFault(recursiveFault)
  );

endmodule

// File: tb/test_trap_entry_ctrl.sv
`timescale 1ns/1ps
module test_trap_entry_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgExcEn = 1'b0;
  logic [31:0] vecBase = '0;
  logic        irqReq = 1'b0, brkReq = 1'b0, hweReq = 1'b0, mmuReq = 1'b0;
  logic [4:0]  hweCause = '0;
  logic        mmuIsFetch = 1'b0, mmuIsStore = 1'b0, mmuIsProt = 1'b0;
  logic [31:0] curPc = '0, curStatus = '0, branchTarget = '0, faultAddrIn = '0;
  logic        inDelaySlot = 1'b0, afterImm = 1'b0, branchUsedImm = 1'b0;
  logic        linkWe, pcWe, statusWe, syndWe, faultAddrWe, btrWe, stateClr, recursiveFault;
  logic [4:0]  linkSel;
  logic [31:0] linkData, pcNext, statusNext, syndNext, faultAddrOut, btrOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_entry_ctrl i_trap_entry_ctrl (
    .clk(clk), .rstN(rstN), .cfgExcEn(cfgExcEn), .vecBase(vecBase),
    .irqReq(irqReq), .brkReq(brkReq), .hweReq(hweReq), .hweCause(hweCause),
    .mmuReq(mmuReq), .mmuIsFetch(mmuIsFetch), .mmuIsStore(mmuIsStore), .mmuIsProt(mmuIsProt),
    .curPc(curPc), .curStatus(curStatus), .inDelaySlot(inDelaySlot), .afterImm(afterImm),
    .branchUsedImm(branchUsedImm), .branchTarget(branchTarget), .faultAddrIn(faultAddrIn),
    .linkWe(linkWe), .linkSel(linkSel), .linkData(linkData), .pcWe(pcWe), .pcNext(pcNext),
    .statusWe(statusWe), .statusNext(statusNext), .syndWe(syndWe), .syndNext(syndNext),
    .faultAddrWe(faultAddrWe), .faultAddrOut(faultAddrOut), .btrWe(btrWe), .btrOut(btrOut),
    .stateClr(stateClr), .recursiveFault(recursiveFault)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] strobesNow();
    return {linkWe, pcWe, statusWe, syndWe, faultAddrWe, btrWe, stateClr, recursiveFault};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "strobes in reset", {24'd0, strobesNow()}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "strobes idle", {24'd0, strobesNow()}, 32'd0);

    for (int i = 0; i < 16384; i++) begin
      logic ds, imm, bimm, ie, eip, bip, hweEff, irqOk, expFault, expBtr, anyTrap;
      logic [31:0] st, expLink, expPc, expSt, expSynd, mode;
      logic [4:0] expSel;
      int kindExp;  // 0 none,1 irq,2 brk,3 hwe,4 mmu
      string tagLink, tagSynd, tagArb;

      irqReq      = i[0];
      brkReq      = i[1];
      hweReq      = i[2];
      mmuReq      = i[3];
      ds          = i[4];
      imm         = i[5];
      bimm        = i[6];
      ie          = i[7];
      eip         = i[8];
      bip         = i[9];
      cfgExcEn    = i[10];
      mmuIsFetch  = i[11];
      mmuIsStore  = i[12];
      mmuIsProt   = i[13];
      inDelaySlot = ds;
      afterImm    = imm;
      branchUsedImm = bimm;
      hweCause    = i[4:0] ^ i[9:5];
      st = 32'hA5C3_0000 ^ (i * 32'h0009_E377);
      st[1] = ie; st[9] = eip; st[3] = bip;
      curStatus    = st;
      curPc        = 32'h0001_0000 + (i << 2);
      vecBase      = 32'h8000_0000 + (i << 8);
      branchTarget = 32'h4000_0000 ^ (i * 32'h0001_0101);
      faultAddrIn  = 32'hF000_0000 ^ (i * 32'h0000_7F13);

      // model from the requirements
      hweEff = hweReq && cfgExcEn;
      irqOk  = irqReq && ie && !eip && !bip && !ds && !imm;
      if (mmuReq)      kindExp = 4;
      else if (hweEff) kindExp = 3;
      else if (brkReq) kindExp = 2;
      else if (irqOk)  kindExp = 1;
      else             kindExp = 0;
      anyTrap = (kindExp != 0);
      expSt = st; expSynd = 32'd0; expLink = curPc; expSel = 5'd17;
      expPc = vecBase + 32'h20;
      tagLink = "R8"; tagSynd = "R9";
      case (kindExp)
        1: begin expSel = 5'd14; expPc = vecBase + 32'h10; expSt[1] = 1'b0; tagLink = "R5"; end
        2: begin expSel = 5'd16; expPc = vecBase + 32'h18; expSt[3] = 1'b1; tagLink = "R6"; end
        3: begin
          expLink = curPc + 32'd4; expSt[9] = 1'b1; tagLink = "R7"; tagSynd = "R7";
          expSynd = {27'd0, hweCause}; expSynd[12] = ds;
        end
        4: begin
          if (ds) expLink = bimm ? curPc - 32'd8 : curPc - 32'd4;
          else if (imm) expLink = curPc - 32'd4;
          else expLink = curPc;
          expSt[9] = 1'b1;
          expSynd = 32'd16 + (mmuIsProt ? 32'd0 : 32'd2) + (mmuIsFetch ? 32'd1 : 32'd0);
          expSynd[10] = mmuIsStore && !mmuIsFetch;
          expSynd[12] = ds;
        end
        default: ;
      endcase
      mode = 32'd0;
      mode[12] = expSt[11];
      mode[14] = expSt[13];
      expSt[11] = 1'b0; expSt[12] = 1'b0; expSt[13] = 1'b0; expSt[14] = 1'b0;
      expSt = expSt | mode;
      expFault = (kindExp == 4) || ((kindExp == 3) && (hweCause == 5'd1));
      expBtr   = ((kindExp == 3) || (kindExp == 4)) && ds;

      if (hweReq && !cfgExcEn && !mmuReq) tagArb = "R12";
      else if (irqReq && !mmuReq && !hweEff && !brkReq) tagArb = "R4";
      else tagArb = "R3";

      @(negedge clk);
      check(tagArb, "link/pc/status strobes", {29'd0, linkWe, pcWe, statusWe}, {29'd0, {3{anyTrap}}});
      check("R11", "stateClr", {31'd0, stateClr}, {31'd0, anyTrap});
      check(tagSynd, "syndWe", {31'd0, syndWe}, {31'd0, (kindExp >= 3)});
      check("R14", "faultAddrWe", {31'd0, faultAddrWe}, {31'd0, expFault});
      check(tagLink, "btrWe", {31'd0, btrWe}, {31'd0, expBtr});
      check("R13", "recursiveFault idle", {31'd0, recursiveFault}, 32'd0);
      if (anyTrap) begin
        check(tagArb, "linkSel", {27'd0, linkSel}, {27'd0, expSel});
        check(tagLink, "linkData", linkData, expLink);
        check("R2", "pcNext", pcNext, expPc);
        check("R10", "statusNext", statusNext, expSt);
      end
      if (kindExp >= 3) check(tagSynd, "syndNext", syndNext, expSynd);
      if (expFault) check("R14", "faultAddrOut", faultAddrOut, faultAddrIn);
      if (expBtr) check(tagLink, "btrOut", btrOut, branchTarget);

      irqReq = 1'b0; brkReq = 1'b0; hweReq = 1'b0; mmuReq = 1'b0;
      @(negedge clk);
      check("R1", "strobes after idle cycle", {24'd0, strobesNow()}, 32'd0);
    end

    // R13: MMU fault held across two cycles, with a hardware exception also pending
    cfgExcEn = 1'b1; inDelaySlot = 1'b0; afterImm = 1'b0;
    curStatus = 32'd0; curPc = 32'h0000_2000; vecBase = 32'h0000_0100;
    mmuReq = 1'b1;
    @(negedge clk);
    check("R13", "first MMU fault taken", {31'd0, pcWe}, 32'd1);
    check("R13", "first MMU vector", pcNext, 32'h0000_0120);
    hweReq = 1'b1;
    @(negedge clk);
    check("R13", "recursiveFault raised", {31'd0, recursiveFault}, 32'd1);
    check("R13", "no trap on recursion", {28'd0, pcWe, linkWe, statusWe, stateClr}, 32'd0);
    mmuReq = 1'b0; hweReq = 1'b0;
    @(negedge clk);
    check("R13", "recursiveFault one cycle", {31'd0, recursiveFault}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule